// File: doc/BRIEF.md
# Programmable Tap-Select Binary Timer

This block is a 24-stage binary up-counter on a single clock. Any one of its sixteen upper stages can be routed to a single timer output. Stage 9 is the lowest selectable stage and stage 24 the highest, so the timer output is a square wave whose period is a power of two between 2^9 and 2^24 clock edges. A skip control shortens the chain: stages 1 to 8 are left out and each clock edge advances stage 9 directly. With the skip control, the selectable periods run from 2 to 2^16 edges.

Every control is sampled on the rising edge. Inhibit freezes the count. The clear control zeroes all stages and the preset control loads all of them with ones. When skip, preset and clear are all high together, the block enters a split test mode instead of clearing. In that mode the chain breaks into three 8-stage sections that count side by side, so the upper stages can be exercised quickly.

The timer output can also be taken from a digital one-shot instead of straight from the selected stage. The one-shot is a two-state machine. In IDLE it waits for the selected stage to rise. The rising edge is the transition IDLE to ACTIVE, and it loads a length counter. In ACTIVE the output is high and the counter runs down. When the last cycle of the pulse is reached, the machine takes the transition ACTIVE to IDLE. Clearing the block forces the machine back to IDLE. The chain's per-edge action is decoded as one of COUNT, HOLD, PRESET, CLEAR and SPLIT.

Top module: `prog_tap_timer`

## Requirements
- R1: With clear, preset and inhibit low and skip low, each rising edge adds 1 to the 24-bit count, and the count wraps from all ones to 0.
- R2: With skip high (and no clear, preset or inhibit), each edge adds 1 to stages 9 to 24 while stages 1 to 8 keep their value. Those stages resume counting from the kept value once skip goes low.
- R3: With the one-shot off, the timer output equals stage 9 + select, meaning count bit 8 + select, where select 0 is stage 9 and select 15 is stage 24. It follows select changes without a clock edge.
- R4: While inhibit is high and neither clear nor preset is high, the count does not change.
- R5: Clear (without the test combination) sets every stage to 0 on the next edge and takes priority over preset.
- R6: Preset alone (clear low) sets every stage to 1 on the next edge, with priority over inhibit.
- R7: When skip, preset and clear are all high, each edge adds 1 to each 8-stage section (stages 1-8, 9-16, 17-24) independently, with no carry between sections, regardless of inhibit.
- R8: With the one-shot on, a 0-to-1 change of the selected stage makes the output high from the next edge for exactly L cycles, where L is the length input, and a length of 0 counts as 1.
- R9: A rise of the selected stage while a pulse is active neither extends nor restarts it.
- R10: Clear ends any active pulse on the next edge and returns the one-shot to IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| clr | input | 1 | Clears all stages and the one-shot |
| preset | input | 1 | Loads all stages with ones |
| hold | input | 1 | Inhibit: freezes the count |
| skip_low | input | 1 | Skips stages 1 to 8 |
| tap_sel | input | 4 | Stage select, 0 = stage 9 to 15 = stage 24 |
| mono_en | input | 1 | Takes the output from the one-shot |
| mono_len | input | 8 | One-shot pulse length in cycles |
| tap_out | output | 1 | Timer output |

## Verification
On every cycle, the assertions check the chain's per-action next state: the increment, the frozen lower section under skip, the freeze under inhibit, the all-ones preset and the zeroed clear. They also check the direct tap path and the one-shot's countdown, which must not retrigger. The split test mode, wrap-around, carry timing across long skip runs and exact pulse lengths are shown only by the bench. The bench sweeps all sixteen select codes every cycle against an arithmetic model of the counter, over tens of thousands of edges with inhibit toggled, and runs one-shot scenarios with several lengths and tap rates.

// File: rtl/ptt_pkg.sv
package ptt_pkg;

    // Action the counter chain takes on the next rising edge
    typedef enum logic [2:0] {
        ACT_COUNT  = 3'd0,
        ACT_HOLD   = 3'd1,
        ACT_PRESET = 3'd2,
        ACT_CLEAR  = 3'd3,
        ACT_SPLIT  = 3'd4
    } chain_act_e;

    // One-shot states
    typedef enum logic {
        OS_IDLE   = 1'b0,
        OS_ACTIVE = 1'b1
    } os_state_e;

endpackage

// File: rtl/ptt_mode_decode.sv
module ptt_mode_decode
    import ptt_pkg::*;
(
    input  logic       clr,
    input  logic       preset,
    input  logic       hold,
    input  logic       skip_low,
    output chain_act_e act
);

    logic split_combo;

    assign split_combo = skip_low & preset & clr;

    // Priority: split test > clear > preset > inhibit > count
    always_comb begin
        if (split_combo) begin
            act = ACT_SPLIT;
        end else if (clr) begin
            act = ACT_CLEAR;
        end else if (preset) begin
            act = ACT_PRESET;
        end else if (hold) begin
            act = ACT_HOLD;
        end else begin
            act = ACT_COUNT;
        end
    end

endmodule

// File: rtl/ptt_stage_chain.sv
module ptt_stage_chain
    import ptt_pkg::*;
#(
    parameter  int SEC_W  = 8,
    parameter  int N_SEC  = 3,
    localparam int STAGES = SEC_W * N_SEC
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              preset,
    input  logic              skip_low,
    input  chain_act_e        act,
    output logic [STAGES-1:0] count_q
);

    logic [N_SEC-1:0]  cin;
    logic [N_SEC-1:0]  cout;
    logic [STAGES-1:0] step_val;
    logic [STAGES-1:0] count_d;
    logic              split_on;

    assign split_on = (act == ACT_SPLIT);

    // Per-section incrementers; carries are cut in split mode, and the
    // lowest section is starved of its carry-in while skipping.
    for (genvar k = 0; k < N_SEC; k++) begin : g_sec
        if (k == 0) begin : g_first
            assign cin[k] = split_on | ~skip_low;
        end else if (k == 1) begin : g_second
            assign cin[k] = split_on | skip_low | cout[k-1];
        end else begin : g_upper
            assign cin[k] = split_on | cout[k-1];
        end

        assign cout[k] = cin[k] & (&count_q[k*SEC_W +: SEC_W]);
        assign step_val[k*SEC_W +: SEC_W] =
            count_q[k*SEC_W +: SEC_W] + {{(SEC_W-1){1'b0}}, cin[k]};
    end

    always_comb begin
        unique case (act)
            ACT_CLEAR:  count_d = '0;
            ACT_PRESET: count_d = '1;
            ACT_HOLD:   count_d = count_q;
            ACT_COUNT:  count_d = step_val;
            ACT_SPLIT:  count_d = step_val;
            default:    count_d = count_q;
        endcase
    end

    always_ff @(posedge clk) begin
        count_q <= count_d;
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (clr)
        (act == ACT_COUNT && !skip_low) |=> count_q == $past(count_q) + STAGES'(1)); // R1

    AST_SKIP_LOW_FROZEN: assert property (@(posedge clk) disable iff (clr)
        (act == ACT_COUNT && skip_low) |=>
            (count_q[SEC_W-1:0] == $past(count_q[SEC_W-1:0])) &&
            (count_q[STAGES-1:SEC_W] == $past(count_q[STAGES-1:SEC_W]) + (STAGES-SEC_W)'(1))); // R2

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (clr)
        (act == ACT_HOLD) |=> $stable(count_q)); // R4

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (clr)
        ($past(clr) && !$past(preset && skip_low)) |-> (count_q == '0)); // R5

    AST_PRESET_ONES: assert property (@(posedge clk) disable iff (clr)
        (act == ACT_PRESET) |=> (&count_q)); // R6

endmodule

// File: rtl/ptt_tap_mux.sv
module ptt_tap_mux #(
    parameter  int N_TAP = 16,
    localparam int SEL_W = $clog2(N_TAP)
) (
    input  logic [N_TAP-1:0] upper,
    input  logic [SEL_W-1:0] sel,
    output logic             tap
);

    logic [N_TAP-1:0] onehot;
    logic [N_TAP-1:0] hits;

    for (genvar g = 0; g < N_TAP; g++) begin : g_tap
        assign onehot[g] = (sel == SEL_W'(g));
        assign hits[g]   = onehot[g] & upper[g];
    end

    assign tap = |hits;

endmodule

// File: rtl/ptt_oneshot.sv
module ptt_oneshot
    import ptt_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             trig_lvl,
    input  logic [LEN_W-1:0] len,
    output logic             pulse
);

    os_state_e        st_q, st_d;
    logic [LEN_W-1:0] rem_q, rem_d;
    logic             lvl_q;
    logic             rise;
    logic [LEN_W-1:0] load_len;

    assign rise     = trig_lvl & ~lvl_q;
    assign load_len = (len == '0) ? LEN_W'(1) : len;

    // State register
    always_ff @(posedge clk) begin
        if (clr) begin
            st_q  <= OS_IDLE;
            rem_q <= '0;
            lvl_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            rem_q <= rem_d;
            lvl_q <= trig_lvl;
        end
    end

    // Next state and outputs
    always_comb begin
        st_d  = st_q;
        rem_d = rem_q;
        pulse = 1'b0;
        unique case (st_q)
            OS_IDLE: begin
                if (rise) begin
                    st_d  = OS_ACTIVE;
                    rem_d = load_len;
                end
            end
            OS_ACTIVE: begin
                pulse = 1'b1;
                if (rem_q <= LEN_W'(1)) begin
                    st_d  = OS_IDLE;
                end else begin
                    rem_d = rem_q - LEN_W'(1);
                end
            end
            default: st_d = OS_IDLE;
        endcase
    end

    AST_RISE_STARTS: assert property (@(posedge clk) disable iff (clr)
        (st_q == OS_IDLE && rise) |=> (pulse && rem_q != '0)); // R8

    AST_ACTIVE_NONZERO: assert property (@(posedge clk) disable iff (clr)
        (st_q == OS_ACTIVE) |-> (rem_q != '0)); // R8

    AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (clr)
        (st_q == OS_ACTIVE && rem_q > LEN_W'(1)) |=>
            (st_q == OS_ACTIVE && rem_q == $past(rem_q) - LEN_W'(1))); // R9

    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (clr)
        $past(clr) |-> (st_q == OS_IDLE && !pulse)); // R10

endmodule

// File: rtl/prog_tap_timer.sv
module prog_tap_timer
    import ptt_pkg::*;
#(
    parameter  int SEC_W  = 8,
    parameter  int N_SEC  = 3,
    parameter  int LEN_W  = 8,
    localparam int STAGES = SEC_W * N_SEC,
    localparam int N_TAP  = STAGES - SEC_W,
    localparam int SEL_W  = $clog2(N_TAP)
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             preset,
    input  logic             hold,
    input  logic             skip_low,
    input  logic [SEL_W-1:0] tap_sel,
    input  logic             mono_en,
    input  logic [LEN_W-1:0] mono_len,
    output logic             tap_out
);

    chain_act_e        act;
    logic [STAGES-1:0] count_q;
    logic              tap_raw;
    logic              pulse;

    ptt_mode_decode u_decode (
        .clr      (clr),
        .preset   (preset),
        .hold     (hold),
        .skip_low (skip_low),
        .act      (act)
    );

    ptt_stage_chain #(
        .SEC_W (SEC_W),
        .N_SEC (N_SEC)
    ) u_chain (
        .clk      (clk),
        .clr      (clr),
        .preset   (preset),
        .skip_low (skip_low),
        .act      (act),
        .count_q  (count_q)
    );

    ptt_tap_mux #(
        .N_TAP (N_TAP)
    ) u_mux (
        .upper (count_q[STAGES-1:SEC_W]),
        .sel   (tap_sel),
        .tap   (tap_raw)
    );

    ptt_oneshot #(
        .LEN_W (LEN_W)
    ) u_shot (
        .clk      (clk),
        .clr      (clr),
        .trig_lvl (tap_raw),
        .len      (mono_len),
        .pulse    (pulse)
    );

    assign tap_out = mono_en ? pulse : tap_raw;

    AST_DIRECT_PATH: assert property (@(posedge clk) disable iff (clr)
        !mono_en |-> (tap_out == count_q[SEC_W + int'(tap_sel)])); // R3

endmodule

// File: tb/sim_prog_tap_timer.sv
module sim_prog_tap_timer;

    localparam int TCLK = 40;

    logic       clk      = 1'b0;
    logic       clr      = 1'b1;
    logic       preset   = 1'b0;
    logic       hold     = 1'b0;
    logic       skip_low = 1'b0;
    logic [3:0] tap_sel  = 4'd0;
    logic       mono_en  = 1'b0;
    logic [7:0] mono_len = 8'd1;
    logic       tap_out;

    int n_run  = 0;
    int n_fail = 0;

    // Arithmetic model state
    logic [23:0] m_cnt;
    logic        m_busy = 1'b0;
    int          m_rem  = 0;
    logic        m_prev = 1'b0;

    always #(TCLK/2) clk = ~clk;

    prog_tap_timer u0 (
        .clk      (clk),
        .clr      (clr),
        .preset   (preset),
        .hold     (hold),
        .skip_low (skip_low),
        .tap_sel  (tap_sel),
        .mono_en  (mono_en),
        .mono_len (mono_len),
        .tap_out  (tap_out)
    );

    always @(posedge clk) begin : model
        logic [23:0] nxt;
        logic        tapv;
        tapv = m_cnt[8 + int'(tap_sel)];
        if (skip_low && preset && clr)
            nxt = {m_cnt[23:16] + 8'd1, m_cnt[15:8] + 8'd1, m_cnt[7:0] + 8'd1};
        else if (clr)      nxt = 24'd0;
        else if (preset)   nxt = 24'hFFFFFF;
        else if (hold)     nxt = m_cnt;
        else if (skip_low) nxt = {m_cnt[23:8] + 16'd1, m_cnt[7:0]};
        else               nxt = m_cnt + 24'd1;
        if (clr) begin
            m_busy = 1'b0;
            m_prev = 1'b0;
        end else begin
            if (m_busy) begin
                m_rem = m_rem - 1;
                if (m_rem == 0) m_busy = 1'b0;
            end else if (tapv && !m_prev) begin
                m_busy = 1'b1;
                m_rem  = (mono_len == 8'd0) ? 1 : int'(mono_len);
            end
            m_prev = tapv;
        end
        m_cnt = nxt;
    end

    task automatic chk(input logic got, input logic exp, input string req, input int idx);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s (idx %0d): got %b expected %b", req, idx, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Check every select code against the model count
    task automatic sweep(input string req);
        logic [3:0] keep;
        keep = tap_sel;
        for (int s = 0; s < 16; s++) begin
            tap_sel = 4'(s);
            #1;
            chk(tap_out, m_cnt[8 + s], req, s);
        end
        tap_sel = keep;
        #1;
    endtask

    task automatic shot_run(input int cycles, input string req);
        for (int i = 0; i < cycles; i++) begin
            step();
            chk(tap_out, m_busy, req, i);
        end
    endtask

    initial begin : watchdog
        #(TCLK * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        // R5: reset state
        step();
        sweep("R5 reset");
        clr = 1'b0;

        // R1 R3 R4: full chain with inhibit pattern
        for (int i = 0; i < 3000; i++) begin
            hold = (i % 7 == 3);
            step();
            sweep("R1 R3 R4");
        end
        hold = 1'b1;
        repeat (5) step();
        sweep("R4 hold");
        hold = 1'b0;

        // R6 preset, then R1 wrap to zero
        preset = 1'b1;
        hold   = 1'b1;
        step();
        sweep("R6 preset");
        preset = 1'b0;
        hold   = 1'b0;
        step();
        sweep("R1 wrap");

        // R5: clear wins over preset
        preset = 1'b1;
        step();
        clr = 1'b1;
        step();
        sweep("R5 priority");
        clr    = 1'b0;
        preset = 1'b0;

        // Leave lower stages at a nonzero value before skipping
        repeat (5) step();

        // R2: skip mode across the whole upper range
        skip_low = 1'b1;
        for (int i = 0; i < 40000; i++) begin
            hold = (i % 11 == 5);
            step();
            sweep("R2 R3");
        end
        hold     = 1'b0;
        skip_low = 1'b0;
        for (int i = 0; i < 300; i++) begin
            step();
            sweep("R2 resume");
        end

        // R7: split test mode, inhibit ignored
        clr = 1'b1;
        step();
        preset   = 1'b1;
        skip_low = 1'b1;
        for (int i = 0; i < 600; i++) begin
            hold = (i % 5 == 0);
            step();
            sweep("R7 split");
        end
        hold     = 1'b0;
        clr      = 1'b0;
        preset   = 1'b0;
        skip_low = 1'b0;
        step();
        sweep("R7 exit");

        // One-shot scenarios
        clr = 1'b1;
        step();
        clr      = 1'b0;
        skip_low = 1'b1;
        tap_sel  = 4'd0;
        mono_len = 8'd3;
        mono_en  = 1'b1;
        shot_run(100, "R9 retrigger");
        tap_sel  = 4'd2;
        mono_len = 8'd2;
        shot_run(100, "R8 len2");
        mono_len = 8'd0;
        shot_run(100, "R8 len0");
        tap_sel  = 4'd3;
        mono_len = 8'd5;
        shot_run(60, "R8 len5");
        for (int i = 0; i < 40 && !m_busy; i++) step();
        chk(tap_out, 1'b1, "R10 pulse active", 0);
        clr = 1'b1;
        step();
        chk(tap_out, m_busy, "R10 clear", 1);
        chk(tap_out, 1'b0, "R10 idle", 2);
        clr = 1'b0;
        shot_run(50, "R8 after clear");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule